// File: doc/BRIEF.md
# Three-Phase Half-Bridge Gate Command Logic

This block turns per-phase switching commands into gate enables for the three half-bridges (U, V, W) of an inverter. Each phase has an active-high high-side command and an active-high low-side command. An active-low shutdown input is shared by all three phases. Each phase also has two undervoltage flags that arrive already digitised: one for the low-voltage supply and one for the bootstrap supply. The block drives one high-side enable and one low-side enable per phase.

The commands and the shutdown input are resynchronised to the block clock. A shoot-through interlock forces a phase off when both of its commands are high. Each phase then enforces its own dead time, counted in clock cycles, after either of its outputs turns off. A low supply flag turns the whole phase off, and a low bootstrap flag turns off only its high side. The block is placed between a PWM controller and the gate drivers.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While the synchronised shutdown input is low, every gate output is low. A low level on `shdn_ni` is visible at the outputs on the third rising clock edge after the change.
- R2: In a phase whose two commands are both high, both gate outputs are low. The two outputs of a phase are never high together.
- R3: In a phase whose two commands are both low, both gate outputs are low.
- R4: With shutdown inactive and no undervoltage, a phase drives only its low-side output when only the low-side command is high, and only its high-side output when only the high-side command is high. A command change reaches the output on the third rising edge after it, and not before, provided the dead time has expired.
- R5: After either output of a phase falls, both outputs of that phase stay low for at least DEAD_CYC cycles (default 36). A turn-on request that is already waiting rises exactly DEAD_CYC cycles after the fall.
- R6: A high `vcc_low_i[p]` forces both outputs of phase p low at the next rising clock edge.
- R7: A high `boot_low_i[p]` forces the high-side output of phase p low at the next rising clock edge and does not affect its low-side output.
- R8: During reset all outputs are low. Reset leaves every dead-time counter expired, so the first turn-on after reset waits only for the synchroniser.
- R9: Phases are independent. A command, flag or dead-time count on one phase changes no output of another phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shdn_ni | input | 1 | Shared shutdown, active low |
| hi_cmd_i | input | NUM_PH | High-side command per phase (bit 0 = U, 1 = V, 2 = W) |
| lo_cmd_i | input | NUM_PH | Low-side command per phase |
| vcc_low_i | input | NUM_PH | Low-voltage supply undervoltage flag per phase |
| boot_low_i | input | NUM_PH | Bootstrap supply undervoltage flag per phase |
| hi_gate_o | output | NUM_PH | High-side gate enable per phase |
| lo_gate_o | output | NUM_PH | Low-side gate enable per phase |

## Verification
The bench applies a lone high-side command from idle. Checking one cycle before and at the third edge separates the synchroniser latency from any dead-time delay, because no dead time is owed after reset. A high-to-low side swap is sampled one cycle before and at the end of the dead window, which shows whether the count is exact. Both-commands-high and both-low patterns check the interlock against the idle case. Shutdown, supply and bootstrap flags are applied to one phase while another phase stays on, which separates a whole-phase lockout from a high-side-only lockout and shows whether a flag leaks across phases.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  // drive table: shutdown wins, conflicting or idle commands leave the bridge open
  function automatic gate_pair_t table_drive(logic sd_n, logic h, logic l);
    gate_pair_t r;
    r.hi = sd_n & h & ~l;
    r.lo = sd_n & l & ~h;
    return r;
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/hb_phase.sv
module hb_phase
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYC = 36
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sd_n_i,
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic vcc_low_i,
  input  logic boot_low_i,
  output logic hi_o,
  output logic lo_o
);

  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);

  gate_pair_t    req;
  logic          want_hi, want_lo;
  logic          hi_q, lo_q, hi_n, lo_n;
  logic          expired, fall;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    req     = table_drive(sd_n_i, hi_cmd_i, lo_cmd_i);
    want_hi = req.hi & ~vcc_low_i & ~boot_low_i;
    want_lo = req.lo & ~vcc_low_i;
    expired = (cnt_q == '0);
    // turn-on only from fully open bridge with dead time spent
    hi_n    = want_hi & (hi_q | (expired & ~lo_q));
    lo_n    = want_lo & (lo_q | (expired & ~hi_q));
    fall    = (hi_q & ~hi_n) | (lo_q & ~lo_n);
    if (fall)         cnt_n = CW'(DEAD_CYC - 1);
    else if (expired) cnt_n = '0;
    else              cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      cnt_q <= cnt_n;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int NUM_PH   = 3,
  parameter int DEAD_CYC = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shdn_ni,
  input  logic [NUM_PH-1:0] hi_cmd_i,
  input  logic [NUM_PH-1:0] lo_cmd_i,
  input  logic [NUM_PH-1:0] vcc_low_i,
  input  logic [NUM_PH-1:0] boot_low_i,
  output logic [NUM_PH-1:0] hi_gate_o,
  output logic [NUM_PH-1:0] lo_gate_o
);

  localparam int SW = 2 * NUM_PH + 1;

  logic [SW-1:0]     sync_d, sync_q;
  logic              sd_n_s;
  logic [NUM_PH-1:0] hi_s, lo_s;

  assign sync_d = {shdn_ni, hi_cmd_i, lo_cmd_i};

  hb_sync #(.W(SW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_d),
    .q_o    (sync_q)
  );

  assign {sd_n_s, hi_s, lo_s} = sync_q;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    hb_phase #(.DEAD_CYC(DEAD_CYC)) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sd_n_i     (sd_n_s),
      .hi_cmd_i   (hi_s[p]),
      .lo_cmd_i   (lo_s[p]),
      .vcc_low_i  (vcc_low_i[p]),
      .boot_low_i (boot_low_i[p]),
      .hi_o       (hi_gate_o[p]),
      .lo_o       (lo_gate_o[p])
    );
  end

endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
  parameter int NUM_PH   = 3,
  parameter int DEAD_CYC = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              shdn_ni,
  input logic [NUM_PH-1:0] vcc_low_i,
  input logic [NUM_PH-1:0] boot_low_i,
  input logic [NUM_PH-1:0] hi_gate_o,
  input logic [NUM_PH-1:0] lo_gate_o
);

  localparam int QW = $clog2(DEAD_CYC + 1);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R8: assert (hi_gate_o == '0 && lo_gate_o == '0);
    end
  end

  assert_shutdown_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(shdn_ni, 3) |-> (hi_gate_o == '0 && lo_gate_o == '0));

  for (genvar p = 0; p < NUM_PH; p++) begin : g_chk
    logic [QW-1:0] quiet_q;
    logic          seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        quiet_q <= '0;
        seen_q  <= 1'b0;
      end else begin
        seen_q <= seen_q | hi_gate_o[p] | lo_gate_o[p];
        if (hi_gate_o[p] | lo_gate_o[p]) quiet_q <= '0;
        else if (quiet_q < QW'(DEAD_CYC)) quiet_q <= quiet_q + QW'(1);
      end
    end

    assert_no_shoot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hi_gate_o[p] && lo_gate_o[p]));

    assert_dead_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(hi_gate_o[p] | lo_gate_o[p]) && seen_q) |-> (quiet_q >= QW'(DEAD_CYC)));

    assert_vcc_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vcc_low_i[p] |=> (!hi_gate_o[p] && !lo_gate_o[p]));

    assert_boot_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      boot_low_i[p] |=> !hi_gate_o[p]);
  end

endmodule

bind hb_gate_ctrl hb_gate_chk #(
  .NUM_PH   (NUM_PH),
  .DEAD_CYC (DEAD_CYC)
) u_gate_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shdn_ni    (shdn_ni),
  .vcc_low_i  (vcc_low_i),
  .boot_low_i (boot_low_i),
  .hi_gate_o  (hi_gate_o),
  .lo_gate_o  (lo_gate_o)
);

// File: tb/tb_hb_gate_ctrl.sv
module tb_hb_gate_ctrl;

  localparam int NP = 3;
  localparam int DT = 36;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          shdn_ni = 1'b0;
  logic [NP-1:0] hi_cmd_i = '0, lo_cmd_i = '0, vcc_low_i = '0, boot_low_i = '0;
  logic [NP-1:0] hi_gate_o, lo_gate_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [NP-1:0] hi;
    logic [NP-1:0] lo;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;

  hb_gate_ctrl #(.NUM_PH(NP), .DEAD_CYC(DT)) dut (.*);

  always #10 clk_i = ~clk_i;

  // monitor: pops expected items and compares against the outputs
  always begin
    @(chk_ev);
    while (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      n_tests++;
      if (hi_gate_o !== it.hi || lo_gate_o !== it.lo) begin
        n_fail++;
        $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                 it.tag, hi_gate_o, lo_gate_o, it.hi, it.lo);
      end
    end
  end

  task automatic expect_out(logic [NP-1:0] hi, logic [NP-1:0] lo, string tag);
    exp_t it;
    it.hi = hi; it.lo = lo; it.tag = tag;
    exp_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    step(3);
    expect_out('0, '0, "R8 reset outputs low");
    rst_ni = 1'b1; shdn_ni = 1'b1;
    step(6);
    expect_out('0, '0, "R3 idle commands");

    // first turn-on after reset: only synchroniser latency
    hi_cmd_i[0] = 1'b1;
    step(2);
    expect_out('0, '0, "R4 no output before third edge");
    step(1);
    expect_out(3'b001, '0, "R4 R8 high side on at third edge");

    // side swap with dead time
    hi_cmd_i[0] = 1'b0; lo_cmd_i[0] = 1'b1;
    step(3);
    expect_out('0, '0, "R5 high side off after swap");
    step(35);
    expect_out('0, '0, "R5 still in dead window");
    step(1);
    expect_out('0, 3'b001, "R5 R4 low side on after dead time");

    // interlock
    hi_cmd_i[0] = 1'b1;
    step(3);
    expect_out('0, '0, "R2 both commands high");

    // other phase independent
    lo_cmd_i[1] = 1'b1;
    step(3);
    expect_out('0, 3'b010, "R9 phase V low side alone");

    // shutdown
    shdn_ni = 1'b0;
    step(3);
    expect_out('0, '0, "R1 shutdown forces off");
    shdn_ni = 1'b1;
    step(50);
    expect_out('0, 3'b010, "R1 recovery after shutdown");

    // supply lockout
    vcc_low_i[1] = 1'b1;
    step(1);
    expect_out('0, '0, "R6 supply flag forces phase off");
    vcc_low_i[1] = 1'b0;
    step(50);
    expect_out('0, 3'b010, "R6 recovery after supply flag");

    // bootstrap lockout on W high side, V low side untouched
    hi_cmd_i[2] = 1'b1;
    step(3);
    expect_out(3'b100, 3'b010, "R9 R4 phase W high side on");
    boot_low_i = 3'b110;
    step(1);
    expect_out('0, 3'b010, "R7 bootstrap flag drops high side only");
    boot_low_i = '0;
    step(50);
    expect_out(3'b100, 3'b010, "R7 recovery after bootstrap flag");

    step(2);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: hi=%b lo=%b expected run to complete", hi_gate_o, lo_gate_o);
      summary();
    end
  end

endmodule